// File: doc/BRIEF.md
# Serial Converter Link Controller

This block connects a system-clock datapath to a serial analog-to-digital converter and a serial digital-to-analog converter. It moves one 16-bit word per frame in each direction. The receive and transmit sides are separate state machines, and each is paced by its own clock-enable tick. Each tick stands for one period of that converter's serial clock. The two ticks normally run at different rates, for example one tick every four system clocks for the input converter and one every two for the output converter.

A read request starts one input frame. The chip select is pulled low for sixteen tick periods while the incoming bits are collected most significant bit first. The block then publishes the assembled word together with a single-cycle ready pulse, and waits for the next request.

A write request starts the output side only once. After that the transmitter frames word after word without any further request. At the start of each frame it takes whatever value is present on the parallel input, then shifts that value out most significant bit first.

Top module: `conv_link`

## Requirements
- R1: While reset is held, `adc_cs_n` and `dac_sync_n` are 1, `dac_sdo` is 0, `adc_ready` is 0 and `adc_word` is 0.
- R2: A cycle with `rd_req` high while the receiver is idle arms the receiver. The first `adc_tick` seen after that drives `adc_cs_n` low from the next cycle. It stays low until exactly sixteen further `adc_tick` cycles have been sampled and returns high in the cycle after the sixteenth.
- R3: The receiver samples `adc_sdi` at each of those sixteen ticks. The first sampled bit lands in bit 15 of `adc_word` and the last in bit 0.
- R4: `adc_ready` is high for exactly one cycle, in the cycle in which `adc_cs_n` returns high. `adc_word` takes its new value in that same cycle and otherwise holds.
- R5: `rd_req` is ignored while a receive frame is armed, shifting or completing. A request pulse during a frame starts no second frame.
- R6: A cycle with `wr_req` high while the transmitter is idle arms it. The next `dac_tick` drives `dac_sync_n` low for sixteen tick periods. The transmitter then re-arms by itself: `dac_sync_n` is high for at least one cycle and falls again at the next `dac_tick`, with no further `wr_req`.
- R7: At the tick that starts a transmit frame, the transmitter captures `dac_word`. It presents bit 15 on `dac_sdo` first and advances one bit at each later tick. `dac_sdo` is 0 whenever `dac_sync_n` is high.
- R8: The receive and transmit sides run concurrently at independent tick rates, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_tick | input | 1 | One-cycle enable marking each input-converter serial clock period |
| dac_tick | input | 1 | One-cycle enable marking each output-converter serial clock period |
| rd_req | input | 1 | Request one input frame |
| wr_req | input | 1 | Start the free-running output frames |
| adc_sdi | input | 1 | Serial data from the input converter |
| adc_cs_n | output | 1 | Input converter chip select, low while bits are collected |
| dac_sync_n | output | 1 | Output converter frame select, low while bits are sent |
| dac_sdo | output | 1 | Serial data to the output converter |
| dac_word | input | 16 | Parallel word to transmit |
| adc_word | output | 16 | Last received parallel word |
| adc_ready | output | 1 | One-cycle pulse when `adc_word` is updated |

## Verification
The assertions assume that the requests and ticks are synchronous to `clk` and last one cycle per event. They also assume that `adc_sdi` and `dac_word` are stable at the sampling edge. Under those assumptions, a chip-select or sync edge, or a change of the transmit bit, can only follow a tick.

The stimulus drives every input half a cycle away from the sampling edge. It makes ticks by dividing the cycle count, first with the nominal ratios and later with irregular ones. The serial input is a pseudo-random stream that changes every cycle. Requests are issued as single pulses, some of them in the middle of a frame, and also held high for back-to-back reads while the transmitter runs.

// File: rtl/conv_link_pkg.sv
package conv_link_pkg;
    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ARM,
        RX_SHIFT,
        RX_DONE
    } rx_state_e;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_ARM,
        TX_SHIFT
    } tx_state_e;
endpackage

// File: rtl/conv_link_rx.sv
module conv_link_rx
    import conv_link_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic              sdi,
    output logic              cs_n,
    output logic              ready,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        rx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic [WORD_W-1:0] word;
    } rx_regs_t;

    rx_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            RX_IDLE: if (req) r_d.st = RX_ARM;
            RX_ARM: begin
                if (tick) begin
                    r_d.st  = RX_SHIFT;
                    r_d.cnt = '0;
                end
            end
            RX_SHIFT: begin
                if (tick) begin
                    r_d.sh = {r_q.sh[WORD_W-2:0], sdi};
                    if (r_q.cnt == LAST) begin
                        r_d.word = {r_q.sh[WORD_W-2:0], sdi};
                        r_d.st   = RX_DONE;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_DONE: r_d.st = RX_IDLE;
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RX_IDLE, cnt: '0, sh: '0, word: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n  = (r_q.st != RX_SHIFT);
    assign ready = (r_q.st == RX_DONE);
    assign word  = r_q.word;

    // R4: the ready flag never lasts two cycles
    a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R4: the published word only moves together with ready
    a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(word));

    // R2: the select falls only after a tick was seen
    a_r2_cs_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(tick));

    // R2: the select rises only when the frame completes
    a_r2_cs_rise_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> ready);
endmodule

// File: rtl/conv_link_tx.sv
module conv_link_tx
    import conv_link_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              req,
    input  logic [WORD_W-1:0] din,
    output logic              sync_n,
    output logic              sdo
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
    } tx_regs_t;

    tx_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            TX_IDLE: if (req) r_d.st = TX_ARM;
            TX_ARM: begin
                r_d.sh = din;
                if (tick) begin
                    r_d.st  = TX_SHIFT;
                    r_d.cnt = '0;
                end
            end
            TX_SHIFT: begin
                if (tick) begin
                    r_d.sh = {r_q.sh[WORD_W-2:0], 1'b0};
                    if (r_q.cnt == LAST) begin
                        r_d.st = TX_ARM;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: TX_IDLE, cnt: '0, sh: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sync_n = (r_q.st != TX_SHIFT);
    assign sdo    = (r_q.st == TX_SHIFT) & r_q.sh[WORD_W-1];

    // R7: the data line is quiet outside a frame
    a_r7_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n |-> !sdo);

    // R6: a frame begins only after a tick
    a_r6_sync_fall_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_n) |-> $past(tick));

    // R7: inside a frame the bit changes only after a tick
    a_r7_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && $past(!sync_n) && (sdo != $past(sdo))) |-> $past(tick));
endmodule

// File: rtl/conv_link.sv
module conv_link
    import conv_link_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adc_tick,
    input  logic              dac_tick,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              adc_sdi,
    output logic              adc_cs_n,
    output logic              dac_sync_n,
    output logic              dac_sdo,
    input  logic [WORD_W-1:0] dac_word,
    output logic [WORD_W-1:0] adc_word,
    output logic              adc_ready
);
    // R8: the two directions share only clock and reset
    conv_link_rx #(.WORD_W(WORD_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (adc_tick),
        .req   (rd_req),
        .sdi   (adc_sdi),
        .cs_n  (adc_cs_n),
        .ready (adc_ready),
        .word  (adc_word)
    );

    conv_link_tx #(.WORD_W(WORD_W)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (dac_tick),
        .req    (wr_req),
        .din    (dac_word),
        .sync_n (dac_sync_n),
        .sdo    (dac_sdo)
    );
endmodule

// File: tb/conv_link_test.sv
module conv_link_test;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, adc_tick, dac_tick, rd_req, wr_req, adc_sdi;
    logic        adc_cs_n, dac_sync_n, dac_sdo, adc_ready;
    logic [15:0] dac_word, adc_word;

    conv_link uut (
        .clk(clk), .rst_n(rst_n), .adc_tick(adc_tick), .dac_tick(dac_tick),
        .rd_req(rd_req), .wr_req(wr_req), .adc_sdi(adc_sdi),
        .adc_cs_n(adc_cs_n), .dac_sync_n(dac_sync_n), .dac_sdo(dac_sdo),
        .dac_word(dac_word), .adc_word(adc_word), .adc_ready(adc_ready)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int adiv = 4, ddiv = 2;
    int rdy_cnt = 0, sync_rises = 0;
    logic prev_sync = 1'b1;
    logic [31:0] lfsr = 32'h1ACE5EED;

    // behavioural reference: phases 0 idle, 1 armed, 2 shifting, 3 done
    int aph = 0, dph = 0;
    bit aq[$];
    bit dq[$];
    logic [15:0] m_word = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            aph = 0; dph = 0; aq.delete(); dq.delete(); m_word = '0;
        end else begin
            case (aph)
                0: if (rd_req) aph = 1;
                1: if (adc_tick) begin aph = 2; aq.delete(); end
                2: if (adc_tick) begin
                    aq.push_back(adc_sdi);
                    if (aq.size() == 16) begin
                        m_word = '0;
                        foreach (aq[i]) m_word = {m_word[14:0], aq[i]};
                        aph = 3;
                    end
                end
                default: aph = 0;
            endcase
            case (dph)
                0: if (wr_req) dph = 1;
                1: if (dac_tick) begin
                    dph = 2;
                    for (int i = 15; i >= 0; i--) dq.push_back(dac_word[i]);
                end
                default: if (dac_tick) begin
                    void'(dq.pop_front());
                    if (dq.size() == 0) dph = 1;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(adc_cs_n == (aph != 2), "R2 adc_cs_n", 32'(adc_cs_n), 32'(aph != 2));
            chk(adc_ready == (aph == 3), "R4 adc_ready", 32'(adc_ready), 32'(aph == 3));
            chk(adc_word == m_word, "R3 adc_word", 32'(adc_word), 32'(m_word));
            chk(dac_sync_n == (dph != 2), "R6 dac_sync_n", 32'(dac_sync_n), 32'(dph != 2));
            chk(dac_sdo == ((dph == 2) ? dq[0] : 1'b0), "R7 dac_sdo",
                32'(dac_sdo), 32'((dph == 2) ? dq[0] : 1'b0));
            if (adc_ready) rdy_cnt++;
            if (dac_sync_n && !prev_sync) sync_rises++;
            prev_sync = dac_sync_n;
        end
        lfsr     = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        adc_sdi  = lfsr[0];
        dac_word = lfsr[31:16];
        adc_tick = (cyc % adiv) == 0;
        dac_tick = (cyc % ddiv) == 0;
    end

    initial begin
        wait (cyc == 60000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int base;
        rst_n = 1'b0; rd_req = 1'b0; wr_req = 1'b0;
        adc_sdi = 1'b0; adc_tick = 1'b0; dac_tick = 1'b0; dac_word = '0;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(adc_cs_n === 1'b1, "R1 adc_cs_n", 32'(adc_cs_n), 1);
        chk(dac_sync_n === 1'b1, "R1 dac_sync_n", 32'(dac_sync_n), 1);
        chk(dac_sdo === 1'b0, "R1 dac_sdo", 32'(dac_sdo), 0);
        chk(adc_ready === 1'b0, "R1 adc_ready", 32'(adc_ready), 0);
        chk(adc_word === 16'h0, "R1 adc_word", 32'(adc_word), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2, R3, R4: one read frame
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        repeat (120) @(negedge clk);
        chk(rdy_cnt == 1, "R4 one ready pulse", 32'(rdy_cnt), 1);

        // R5: a second pulse inside a busy frame is ignored
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        repeat (20) @(negedge clk);
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        repeat (150) @(negedge clk);
        chk(rdy_cnt == 2, "R5 busy request ignored", 32'(rdy_cnt), 2);
        chk(adc_cs_n == 1'b1, "R5 receiver idle", 32'(adc_cs_n), 1);

        // R6, R7: a single write request starts endless frames
        wr_req = 1'b1; @(negedge clk); wr_req = 1'b0;
        repeat (300) @(negedge clk);
        chk(sync_rises >= 6, "R6 self re-arming frames", 32'(sync_rises), 6);

        // R8: back-to-back reads alongside the running transmitter
        base = rdy_cnt;
        rd_req = 1'b1;
        repeat (400) @(negedge clk);
        rd_req = 1'b0;
        repeat (80) @(negedge clk);
        chk(rdy_cnt - base >= 5, "R8 concurrent reads", 32'(rdy_cnt - base), 5);

        // irregular tick rates on both sides
        adiv = 7; ddiv = 5;
        base = sync_rises;
        rd_req = 1'b1; @(negedge clk); rd_req = 1'b0;
        repeat (400) @(negedge clk);
        chk(sync_rises - base >= 4, "R6 frames at slow tick", 32'(sync_rises - base), 4);
        chk(adc_cs_n == 1'b1, "R2 frame closed at slow tick", 32'(adc_cs_n), 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule